// File: doc/BRIEF.md
# SMRAM and TSEG Access Controller

This block sits in a host bridge and decides, for every memory access, whether that access may reach system-management RAM. Two configuration bytes and a 16-bit extended-size query word are written through a byte-wide configuration port. Each byte is merged with a write mask. A lock bit freezes the SMRAM configuration until the next reset.

Each access arrives as an address with a flag that says whether the processor is in system management mode (SMM). The block classifies the access combinationally into one of four routes: ordinary system decode, DRAM, the legacy PCI/VGA side, or a blackhole. It covers three areas:
- the low legacy window,
- a high alias window,
- a TSEG region carved from the top of below-4G memory.

The blackhole route means a read returns all ones and a write is dropped.

Top module: `smram_tseg_ctrl`

## Requirements
- R1: Reset loads these values:
  - control byte (address 0) reads 0x00;
  - extended control byte (address 1) reads 0x00;
  - the query word (low byte at address 2, high byte at address 3) reads 0xFFFF when the configured extended TSEG size is nonzero;
  - `size_err` is 1 exactly when the configured extended size exceeds the supported maximum.
- R2: A configuration write takes effect on the next clock edge. The new value is (old & ~mask) | (data & mask).
  - Control byte: bit0 open, bit1 lock, bit2 global enable; full mask 0x07.
  - Extended control byte: bit0 TSEG enable, bits 2:1 TSEG size, bit7 high enable; full mask 0x87.
  - Unmasked bits read as 0.
- R3: A control write whose merged lock bit is 1 stores open as 0. From then on, both bytes use an all-zero lock-time mask, so they hold their values until reset.
- R4: Route codes on `acc_route` are 0 for ordinary decode, 1 for DRAM, 2 for PCI/VGA and 3 for blackhole. Addresses outside every window give 0. A non-SMM access to the low window 0x000A0000–0x000BFFFF gives DRAM when open is 1 and high enable is 0. Every other non-SMM access to the low window gives PCI/VGA.
- R5: A non-SMM access to the high window 0xFEDA0000–0xFEDBFFFF gives DRAM when open is 1 and high enable is 1. Otherwise it gives ordinary decode.
- R6: SMM accesses follow these rules:
  - with global enable 1 and high enable 0, an SMM access reaches DRAM in the low window;
  - with global enable 1 and high enable 1, an SMM access reaches DRAM in the high window;
  - in every other case an SMM access is routed as a non-SMM access would be.
- R7: TSEG is decoded only when its enable bit is 1. The size code selects the region size: 0 gives 1 MB, 1 gives 2 MB, 2 gives 8 MB, 3 gives the extended size in MB. The region spans [below-4G size − TSEG size, below-4G size).
- R8: Inside an active TSEG region, non-SMM accesses get the blackhole route (3) and SMM accesses get DRAM (1).
- R9: A write to the query word is stored as written, except in one case. If the merged 16-bit value equals 0xFFFF and the extended size is nonzero, the word reads back the extended size in MB from the next cycle. The query word is not affected by the lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration byte write strobe |
| cfg_waddr | input | 2 | Configuration write byte address |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_raddr | input | 2 | Configuration read byte address |
| cfg_rdata | output | 8 | Configuration read data (combinational) |
| acc_addr | input | 32 | Address of the access being classified |
| acc_smm | input | 1 | Access issued in system management mode |
| acc_route | output | 2 | Route code for the access |
| size_err | output | 1 | Extended TSEG size exceeds supported maximum |

## Verification
The assertions check several rules on every cycle:
- the lock bit never coexists with open, and stays set once set;
- the extended control byte cannot change while locked;
- the blackhole route is never given to an SMM access;
- a closed configuration never hands the low window to a non-SMM access.

Only the bench's scenarios can show the remaining behaviour:
- the exact TSEG boundaries for each size code, including the first and last byte;
- the query-word substitution;
- the masked write values;
- that a post-lock write is truly lost until reset.

// File: rtl/smram_pkg.sv
package smram_pkg;

    // route codes
    typedef enum logic [1:0] {
        RT_DEFAULT = 2'd0,
        RT_DRAM    = 2'd1,
        RT_PCI     = 2'd2,
        RT_HOLE    = 2'd3
    } route_e;

    // configuration byte addresses
    localparam logic [1:0] AD_CTL  = 2'd0;
    localparam logic [1:0] AD_XCTL = 2'd1;
    localparam logic [1:0] AD_QLO  = 2'd2;
    localparam logic [1:0] AD_QHI  = 2'd3;

    // control byte bits
    localparam int CTL_OPEN = 0;
    localparam int CTL_LOCK = 1;
    localparam int CTL_GEN  = 2;
    // extended control byte bits
    localparam int XC_TEN   = 0;
    localparam int XC_TSZ   = 1;
    localparam int XC_HEN   = 7;

    localparam logic [7:0] CTL_MASK_FULL  = 8'h07;
    localparam logic [7:0] XCTL_MASK_FULL = 8'h87;
    localparam logic [7:0] CTL_MASK_LCK   = 8'h00;
    localparam logic [7:0] XCTL_MASK_LCK  = 8'h00;

    localparam logic [15:0] QUERY_CODE = 16'hFFFF;

    // fixed windows
    localparam logic [31:0] LOW_WIN_BASE  = 32'h000A_0000;
    localparam logic [31:0] HIGH_WIN_BASE = 32'hFEDA_0000;
    localparam logic [31:0] WIN_BYTES     = 32'h0002_0000;

    typedef struct packed {
        logic       open;
        logic       lock;
        logic       gen;
        logic       hen;
        logic       ten;
        logic [1:0] tsz;
    } smram_cfg_t;

    function automatic logic [31:0] tseg_bytes(input logic [1:0] code,
                                               input logic [31:0] ext_mb);
        case (code)
            2'd0:    return 32'h0010_0000;
            2'd1:    return 32'h0020_0000;
            2'd2:    return 32'h0080_0000;
            default: return ext_mb << 20;
        endcase
    endfunction

    function automatic logic in_win(input logic [31:0] a, input logic [31:0] base);
        return (a >= base) && (a < base + WIN_BYTES);
    endfunction

endpackage

// File: rtl/smram_cfg_regs.sv
module smram_cfg_regs
    import smram_pkg::*;
#(
    parameter int EXT_MB     = 16,
    parameter int EXT_MAX_MB = 4095
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       we,
    input  logic [1:0] waddr,
    input  logic [7:0] wdata,
    input  logic [1:0] raddr,
    output logic [7:0] rdata,
    output smram_cfg_t cfg,
    output logic       err
);
    localparam logic [15:0] EXT_W   = 16'(EXT_MB);
    localparam logic [15:0] QRY_RST = (EXT_MB != 0) ? QUERY_CODE : 16'h0000;

    logic [7:0]  ctl_q, xctl_q, ctl_nx, xctl_nx;
    logic [15:0] qry_q, qry_nx, qry_mrg;
    logic        locked;

    assign locked = ctl_q[CTL_LOCK];

    always_comb begin
        logic [7:0] cm, xm;
        cm      = locked ? CTL_MASK_LCK  : CTL_MASK_FULL;
        xm      = locked ? XCTL_MASK_LCK : XCTL_MASK_FULL;
        ctl_nx  = ctl_q;
        xctl_nx = xctl_q;
        qry_mrg = qry_q;
        if (we) begin
            case (waddr)
                AD_CTL: begin
                    ctl_nx = (ctl_q & ~cm) | (wdata & cm);
                    if (ctl_nx[CTL_LOCK]) ctl_nx[CTL_OPEN] = 1'b0;
                end
                AD_XCTL: xctl_nx = (xctl_q & ~xm) | (wdata & xm);
                AD_QLO:  qry_mrg = {qry_q[15:8], wdata};
                default: qry_mrg = {wdata, qry_q[7:0]};
            endcase
        end
        qry_nx = ((EXT_MB != 0) && qry_mrg == QUERY_CODE) ? EXT_W : qry_mrg;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q  <= 8'h00;
            xctl_q <= 8'h00;
            qry_q  <= QRY_RST;
            err    <= (EXT_MB > EXT_MAX_MB);
        end else begin
            ctl_q  <= ctl_nx;
            xctl_q <= xctl_nx;
            if (we && (waddr == AD_QLO || waddr == AD_QHI)) qry_q <= qry_nx;
        end
    end

    always_comb begin
        case (raddr)
            AD_CTL:  rdata = ctl_q;
            AD_XCTL: rdata = xctl_q;
            AD_QLO:  rdata = qry_q[7:0];
            default: rdata = qry_q[15:8];
        endcase
    end

    assign cfg.open = ctl_q[CTL_OPEN];
    assign cfg.lock = ctl_q[CTL_LOCK];
    assign cfg.gen  = ctl_q[CTL_GEN];
    assign cfg.hen  = xctl_q[XC_HEN];
    assign cfg.ten  = xctl_q[XC_TEN];
    assign cfg.tsz  = xctl_q[XC_TSZ +: 2];

    // R3: lock and open never both set
    a_r3_lock_closes: assert property (@(posedge clk) disable iff (rst)
        ctl_q[CTL_LOCK] |-> !ctl_q[CTL_OPEN]);
    // R3: lock is sticky until reset
    a_r3_lock_sticky: assert property (@(posedge clk) disable iff (rst)
        ($past(ctl_q[CTL_LOCK]) && !$past(rst)) |-> ctl_q[CTL_LOCK]);
    // R3: extended control frozen while locked
    a_r3_xctl_frozen: assert property (@(posedge clk) disable iff (rst)
        ($past(ctl_q[CTL_LOCK]) && !$past(rst)) |-> $stable(xctl_q));
endmodule

// File: rtl/smram_router.sv
module smram_router
    import smram_pkg::*;
#(
    parameter logic [31:0] BELOW4G = 32'h8000_0000,
    parameter int          EXT_MB  = 16
) (
    input  smram_cfg_t  cfg,
    input  logic [31:0] addr,
    input  logic        smm,
    output route_e      route
);
    logic [31:0] tsz_b, tbase;
    logic        in_low, in_high, in_tseg;
    route_e      plain;

    assign tsz_b   = tseg_bytes(cfg.tsz, 32'(EXT_MB));
    assign tbase   = BELOW4G - tsz_b;
    assign in_low  = in_win(addr, LOW_WIN_BASE);
    assign in_high = in_win(addr, HIGH_WIN_BASE);
    assign in_tseg = cfg.ten && (addr >= tbase) && (addr < BELOW4G);

    // view of a non-SMM agent
    always_comb begin
        plain = RT_DEFAULT;
        if (in_low)
            plain = (cfg.open && !cfg.hen) ? RT_DRAM : RT_PCI;
        else if (in_high)
            plain = (cfg.open && cfg.hen) ? RT_DRAM : RT_DEFAULT;
        else if (in_tseg)
            plain = RT_HOLE;
    end

    // SMM overlays its own windows on top of the plain view
    always_comb begin
        route = plain;
        if (smm) begin
            if (in_low && cfg.gen && !cfg.hen)      route = RT_DRAM;
            else if (in_high && cfg.gen && cfg.hen) route = RT_DRAM;
            else if (in_tseg)                       route = RT_DRAM;
        end
    end
endmodule

// File: rtl/smram_tseg_ctrl.sv
module smram_tseg_ctrl
    import smram_pkg::*;
#(
    parameter logic [31:0] BELOW4G    = 32'h8000_0000,
    parameter int          EXT_MB     = 16,
    parameter int          EXT_MAX_MB = 4095
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_we,
    input  logic [1:0]  cfg_waddr,
    input  logic [7:0]  cfg_wdata,
    input  logic [1:0]  cfg_raddr,
    output logic [7:0]  cfg_rdata,
    input  logic [31:0] acc_addr,
    input  logic        acc_smm,
    output logic [1:0]  acc_route,
    output logic        size_err
);
    smram_cfg_t cfg;
    route_e     rt;

    smram_cfg_regs #(.EXT_MB(EXT_MB), .EXT_MAX_MB(EXT_MAX_MB)) u_regs (
        .clk(clk), .rst(rst), .we(cfg_we), .waddr(cfg_waddr), .wdata(cfg_wdata),
        .raddr(cfg_raddr), .rdata(cfg_rdata), .cfg(cfg), .err(size_err)
    );

    smram_router #(.BELOW4G(BELOW4G), .EXT_MB(EXT_MB)) u_route (
        .cfg(cfg), .addr(acc_addr), .smm(acc_smm), .route(rt)
    );

    assign acc_route = rt;

    // R8: blackhole only for non-SMM agents
    a_r8_hole_nonsmm: assert property (@(posedge clk) disable iff (rst)
        (acc_route == 2'd3) |-> !acc_smm);
    // R4: closed configuration keeps low window on PCI for non-SMM
    a_r4_closed_low: assert property (@(posedge clk) disable iff (rst)
        (!cfg.open && !acc_smm && in_win(acc_addr, LOW_WIN_BASE)) |-> (acc_route == 2'd2));
    // R6: enabled SMRAM in low window reaches DRAM for SMM
    a_r6_smm_low: assert property (@(posedge clk) disable iff (rst)
        (acc_smm && cfg.gen && !cfg.hen && in_win(acc_addr, LOW_WIN_BASE)) |-> (acc_route == 2'd1));
    // R5: high alias never maps DRAM to non-SMM unless open
    a_r5_high_closed: assert property (@(posedge clk) disable iff (rst)
        (!cfg.open && !acc_smm && in_win(acc_addr, HIGH_WIN_BASE)) |-> (acc_route == 2'd0));
endmodule

// File: tb/sim_smram_tseg_ctrl.sv
module sim_smram_tseg_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_waddr = 2'd0;
    logic [7:0]  cfg_wdata = 8'h00;
    logic [1:0]  cfg_raddr = 2'd0;
    logic [7:0]  cfg_rdata, rdata1;
    logic [31:0] acc_addr = 32'h0;
    logic        acc_smm = 1'b0;
    logic [1:0]  acc_route, route1;
    logic        size_err, err1;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    smram_tseg_ctrl u0 (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_waddr(cfg_waddr),
        .cfg_wdata(cfg_wdata), .cfg_raddr(cfg_raddr), .cfg_rdata(cfg_rdata),
        .acc_addr(acc_addr), .acc_smm(acc_smm), .acc_route(acc_route),
        .size_err(size_err)
    );

    smram_tseg_ctrl #(.EXT_MB(200), .EXT_MAX_MB(100)) u1 (
        .clk(clk), .rst(rst), .cfg_we(1'b0), .cfg_waddr(2'd0),
        .cfg_wdata(8'h00), .cfg_raddr(2'd0), .cfg_rdata(rdata1),
        .acc_addr(32'h0), .acc_smm(1'b0), .acc_route(route1),
        .size_err(err1)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_waddr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [1:0] a, input logic [7:0] exp);
        cfg_raddr = a; #1;
        check(req, {24'h0, cfg_rdata}, {24'h0, exp});
    endtask

    task automatic rt_chk(input string req, input logic [31:0] a, input logic smm,
                          input logic [1:0] exp);
        @(negedge clk);
        acc_addr = a; acc_smm = smm; #1;
        check(req, {30'h0, acc_route}, {30'h0, exp});
    endtask

    task automatic t_reset();
        do_reset();
        rd_chk("R1", 2'd0, 8'h00);
        rd_chk("R1", 2'd1, 8'h00);
        rd_chk("R1", 2'd2, 8'hFF);
        rd_chk("R1", 2'd3, 8'hFF);
        check("R1", {31'h0, size_err}, 32'h0);
        check("R1", {31'h0, err1}, 32'h1);
        rt_chk("R4", 32'h000A_0000, 1'b0, 2'd2);
        rt_chk("R6", 32'h000B_FFFF, 1'b1, 2'd2);
        rt_chk("R4", 32'h0010_0000, 1'b0, 2'd0);
    endtask

    task automatic t_masks();
        do_reset();
        wr(2'd0, 8'hFD);
        rd_chk("R2", 2'd0, 8'h05);
        wr(2'd1, 8'hFF);
        rd_chk("R2", 2'd1, 8'h87);
    endtask

    task automatic t_windows();
        do_reset();
        wr(2'd0, 8'h01);            // open
        rt_chk("R4", 32'h000A_0000, 1'b0, 2'd1);
        rt_chk("R4", 32'h0009_FFFF, 1'b0, 2'd0);
        rt_chk("R5", 32'hFEDA_0000, 1'b0, 2'd0);
        wr(2'd1, 8'h80);            // high enable
        rt_chk("R4", 32'h000B_FFFF, 1'b0, 2'd2);
        rt_chk("R5", 32'hFEDB_FFFF, 1'b0, 2'd1);
        rt_chk("R5", 32'hFEDC_0000, 1'b0, 2'd0);
        wr(2'd0, 8'h04);            // closed, global enable
        rt_chk("R5", 32'hFEDA_0000, 1'b0, 2'd0);
        rt_chk("R6", 32'hFEDA_0000, 1'b1, 2'd1);
        rt_chk("R6", 32'h000A_0000, 1'b1, 2'd2);
        wr(2'd1, 8'h00);            // high enable off
        rt_chk("R6", 32'h000A_0000, 1'b1, 2'd1);
        rt_chk("R6", 32'hFEDA_0000, 1'b1, 2'd0);
        rt_chk("R4", 32'h000A_0000, 1'b0, 2'd2);
    endtask

    task automatic t_tseg();
        do_reset();
        rt_chk("R7", 32'h7FFF_FFFF, 1'b0, 2'd0);
        wr(2'd1, 8'h01);            // 1 MB
        rt_chk("R7", 32'h7FF0_0000, 1'b0, 2'd3);
        rt_chk("R7", 32'h7FEF_FFFF, 1'b0, 2'd0);
        rt_chk("R8", 32'h7FFF_FFFF, 1'b0, 2'd3);
        rt_chk("R7", 32'h8000_0000, 1'b0, 2'd0);
        rt_chk("R8", 32'h7FF0_0000, 1'b1, 2'd1);
        wr(2'd1, 8'h03);            // 2 MB
        rt_chk("R7", 32'h7FE0_0000, 1'b0, 2'd3);
        rt_chk("R7", 32'h7FDF_FFFF, 1'b0, 2'd0);
        wr(2'd1, 8'h05);            // 8 MB
        rt_chk("R7", 32'h7F80_0000, 1'b0, 2'd3);
        rt_chk("R7", 32'h7F7F_FFFF, 1'b0, 2'd0);
        wr(2'd1, 8'h07);            // extended 16 MB
        rt_chk("R7", 32'h7F00_0000, 1'b0, 2'd3);
        rt_chk("R7", 32'h7EFF_FFFF, 1'b0, 2'd0);
        rt_chk("R8", 32'h7F00_0000, 1'b1, 2'd1);
    endtask

    task automatic t_query();
        do_reset();
        wr(2'd2, 8'h34);
        rd_chk("R9", 2'd2, 8'h34);
        rd_chk("R9", 2'd3, 8'hFF);
        wr(2'd2, 8'hFF);
        rd_chk("R9", 2'd2, 8'h10);
        rd_chk("R9", 2'd3, 8'h00);
    endtask

    task automatic t_lock();
        do_reset();
        wr(2'd0, 8'h07);
        rd_chk("R3", 2'd0, 8'h06);
        rt_chk("R3", 32'h000A_0000, 1'b0, 2'd2);
        wr(2'd0, 8'h01);
        rd_chk("R3", 2'd0, 8'h06);
        wr(2'd1, 8'h87);
        rd_chk("R3", 2'd1, 8'h00);
        wr(2'd3, 8'h12);            // query ignores lock
        rd_chk("R9", 2'd3, 8'h12);
        do_reset();
        wr(2'd0, 8'h01);
        rd_chk("R3", 2'd0, 8'h01);
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_masks();
        t_windows();
        t_tseg();
        t_query();
        t_lock();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule